// File: doc/BRIEF.md
# Loadable 16-bit Pseudo-Random Sequence Generator

This block is a 16-stage shift register with linear feedback that produces a fully deterministic pseudo-random sequence for use as test stimulus. On every enabled clock edge the register moves its contents one place toward the higher index. A single new bit enters at bit 0. That bit is the XOR of the stages whose connection coefficient is set. The coefficients are a parameter, so one piece of RTL can realise any feedback polynomial of degree 16.

The start of the sequence is under full control. A parallel seed path replaces the whole state in one cycle. A given seed always reproduces the same sequence, so a failing test can be replayed exactly. The state is presented as four 4-bit slices. A consumer can therefore take independent 4-bit fields from one register.

Top module: `lfsr_gen16`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes the parameter `RESET_SEED` (default 16'hACE1). This reset takes priority over `load` and `enable`.
- R2: With `rst_n` high and `load` high at a rising edge, the state becomes `seed` in that same edge.
- R3: When `load` and `enable` are both high, the load wins. The state becomes `seed` and no shift happens.
- R4: When `load` and `enable` are both low, the state holds its value. A change of `seed` has no effect in that case.
- R5: With `enable` high and `load` low, the next state is {state[14:0], fb}. Here fb is the XOR over i=1..16 of (c_i AND state[i-1]). Coefficient c_i is bit i-1 of the parameter `COEFF`, whose default is 16'hB400 (c16, c14, c13 and c11 set).
- R6: `q_nib3` carries state bits 15..12, `q_nib2` bits 11..8, `q_nib1` bits 7..4 and `q_nib0` bits 3..0.
- R7: Loading the same seed again and then stepping gives an identical sequence.
- R8: With the default `COEFF` and a nonzero seed, the state first returns to the seed after exactly 65535 enabled steps.
- R9: An all-zero state is a lock-up state. Once loaded with zero, the register stays zero while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to `RESET_SEED` |
| load | input | 1 | Parallel-load strobe, takes priority over enable |
| enable | input | 1 | Advance the sequence by one step |
| seed | input | 16 | Parallel initial state |
| q_nib3 | output | 4 | State bits 15..12 |
| q_nib2 | output | 4 | State bits 11..8 |
| q_nib1 | output | 4 | State bits 7..4 |
| q_nib0 | output | 4 | State bits 3..0 |

## Verification
The hardest condition to reach from the ports is the full-period wrap. It only shows after 65535 consecutive enabled steps. A single wrong tap or a wrong shift direction shortens the period, but it can still leave the first few steps looking plausible. To reach it, the stimulus loads a known seed and holds `enable` for the whole period. At every step it compares the state with an independent model and watches for an early return to the seed. Shorter directed runs cover the other corners: load against enable, hold with a changing seed, reset during a run, and the zero lock-up.

// File: rtl/lfsr_pkg.sv
// Package: shared geometry of the sequence generator.
// Assumes a register length that is a whole number of nibbles.
package lfsr_pkg;
    localparam int STATE_W = 16;
    localparam int NIB_W   = 4;
    localparam int NIB_N   = STATE_W / NIB_W;

    typedef logic [STATE_W-1:0] state_t;
endpackage

// File: rtl/lfsr_feedback.sv
// Module: lfsr_feedback
// Forms the new input bit as the XOR of all stages whose coefficient is set.
// Assumes COEFF bit i-1 holds c_i, which weights stage i-1 (i.e. s[j-i]).
module lfsr_feedback
    import lfsr_pkg::*;
#(
    parameter state_t COEFF = 16'hB400
) (
    input  state_t state_i,
    output logic   fb_o
);
    state_t tapped;

    // One AND gate per stage, selected by its coefficient bit.
    for (genvar i = 0; i < STATE_W; i++) begin : g_tap
        assign tapped[i] = COEFF[i] & state_i[i];
    end

    // Parity of the selected stages is the recursion output.
    always_comb begin
        fb_o = ^tapped;
    end
endmodule

// File: rtl/lfsr_stage.sv
// Module: lfsr_stage
// One D flip-flop of the register, with a seed/shift multiplexer in front.
// Assumes synchronous active-low reset; priority is reset, load, enable.
module lfsr_stage #(
    parameter logic RST_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic enable,
    input  logic seed_bit,
    input  logic shift_in,
    output logic q
);
    // Stage update: reset value, else seed, else shifted bit, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_BIT;
        end else if (load) begin
            q <= seed_bit;
        end else if (enable) begin
            q <= shift_in;
        end
    end
endmodule

// File: rtl/lfsr_nibble_view.sv
// Module: lfsr_nibble_view
// Splits the state into NIB_N slices of NIB_W bits, slice k = bits of weight k.
// Assumes STATE_W is an exact multiple of NIB_W.
module lfsr_nibble_view
    import lfsr_pkg::*;
(
    input  state_t                       state_i,
    output logic [NIB_N-1:0][NIB_W-1:0]  nib_o
);
    // Slice k takes bits k*NIB_W+NIB_W-1 down to k*NIB_W.
    for (genvar k = 0; k < NIB_N; k++) begin : g_nib
        assign nib_o[k] = state_i[k*NIB_W +: NIB_W];
    end
endmodule

// File: rtl/lfsr_gen16.sv
// Module: lfsr_gen16
// 16-stage Fibonacci shift register with parameterised feedback taps,
// a parallel seed load and an enable. The state shifts toward the higher
// index and the feedback bit enters at bit 0.
// Assumes RESET_SEED is nonzero; an all-zero state never leaves zero.
module lfsr_gen16
    import lfsr_pkg::*;
#(
    parameter state_t COEFF      = 16'hB400,
    parameter state_t RESET_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        enable,
    input  logic [15:0] seed,
    output logic [3:0]  q_nib3,
    output logic [3:0]  q_nib2,
    output logic [3:0]  q_nib1,
    output logic [3:0]  q_nib0
);
    state_t                      state_q;
    logic                        fb;
    logic [NIB_N-1:0][NIB_W-1:0] nibs;

    lfsr_feedback #(.COEFF(COEFF)) fb_i (
        .state_i (state_q),
        .fb_o    (fb)
    );

    // Stage chain: stage 0 takes the feedback, stage i takes stage i-1.
    for (genvar i = 0; i < STATE_W; i++) begin : g_stage
        logic shift_in;
        if (i == 0) begin : g_head
            assign shift_in = fb;
        end else begin : g_body
            assign shift_in = state_q[i-1];
        end
        lfsr_stage #(.RST_BIT(RESET_SEED[i])) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .enable   (enable),
            .seed_bit (seed[i]),
            .shift_in (shift_in),
            .q        (state_q[i])
        );
    end

    lfsr_nibble_view view_i (
        .state_i (state_q),
        .nib_o   (nibs)
    );

    // Port mapping of the four slices, most significant first.
    always_comb begin
        q_nib3 = nibs[3];
        q_nib2 = nibs[2];
        q_nib1 = nibs[1];
        q_nib0 = nibs[0];
    end

    // R1: reset forces the reset seed regardless of load and enable.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> state_q == RESET_SEED);

    // R2, R3: a load captures the seed, even with enable high.
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q == $past(seed));

    // R4: idle cycles keep the state.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !enable) |=> $stable(state_q));

    // R5: an enabled step moves every stage one place up.
    a_r5_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load) |=> state_q[STATE_W-1:1] == $past(state_q[STATE_W-2:0]));

    // R9: zero state stays zero under enable.
    a_r9_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load && state_q == '0) |=> state_q == '0);
endmodule

// File: tb/lfsr_gen16_tb_top.sv
// Directed bench for lfsr_gen16: one task per scenario, each checking itself.
module lfsr_gen16_tb_top;
    localparam logic [15:0] TB_COEFF = 16'hB400;
    localparam logic [15:0] TB_RST   = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] seed = 16'h0000;
    logic [3:0]  q_nib3, q_nib2, q_nib1, q_nib0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    lfsr_gen16 #(.COEFF(TB_COEFF), .RESET_SEED(TB_RST)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .enable (enable),
        .seed   (seed),
        .q_nib3 (q_nib3),
        .q_nib2 (q_nib2),
        .q_nib1 (q_nib1),
        .q_nib0 (q_nib0)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 200000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] model_next(input logic [15:0] s);
        return {s[14:0], ^(s & TB_COEFF)};
    endfunction

    function automatic logic [15:0] cur_state();
        return {q_nib3, q_nib2, q_nib1, q_nib0};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Inputs change at negedge; results are read at the following negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] v);
        load = 1'b1; enable = 1'b0; seed = v;
        tick();
        load = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; load = 1'b1; enable = 1'b1; seed = 16'hFFFF;
        tick(); tick();
        check("R1 reset over load", cur_state(), TB_RST);
        rst_n = 1'b1; load = 1'b0; enable = 1'b0;
        tick();
        check("R1 reset value held", cur_state(), TB_RST);
    endtask

    task automatic t_load();
        do_load(16'h5A3C);
        check("R2 load", cur_state(), 16'h5A3C);
        do_load(16'h0001);
        check("R2 load second", cur_state(), 16'h0001);
    endtask

    task automatic t_priority();
        do_load(16'h1111);
        load = 1'b1; enable = 1'b1; seed = 16'hBEEF;
        tick();
        load = 1'b0; enable = 1'b0;
        check("R3 load beats enable", cur_state(), 16'hBEEF);
    endtask

    task automatic t_hold();
        do_load(16'hC0DE);
        for (int k = 0; k < 4; k++) begin
            seed = 16'h1234 + 16'(k);
            tick();
        end
        check("R4 hold with changing seed", cur_state(), 16'hC0DE);
    endtask

    task automatic t_step(input logic [15:0] start, input int n, input string req);
        logic [15:0] exp;
        exp = start;
        do_load(start);
        enable = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick();
            exp = model_next(exp);
            check(req, cur_state(), exp);
        end
        enable = 1'b0;
    endtask

    task automatic t_nibbles();
        do_load(16'h9E27);
        check("R6 nib3", {12'h0, q_nib3}, 16'h0009);
        check("R6 nib2", {12'h0, q_nib2}, 16'h000E);
        check("R6 nib1", {12'h0, q_nib1}, 16'h0002);
        check("R6 nib0", {12'h0, q_nib0}, 16'h0007);
    endtask

    task automatic t_repeat();
        logic [15:0] first [8];
        do_load(16'h7F31);
        enable = 1'b1;
        for (int k = 0; k < 8; k++) begin tick(); first[k] = cur_state(); end
        enable = 1'b0;
        do_load(16'h7F31);
        enable = 1'b1;
        for (int k = 0; k < 8; k++) begin tick(); check("R7 replay", cur_state(), first[k]); end
        enable = 1'b0;
    endtask

    task automatic t_period();
        logic [15:0] exp;
        int early, bad, ret;
        exp = 16'h0001; early = 0; bad = 0; ret = 0;
        do_load(16'h0001);
        enable = 1'b1;
        for (int k = 1; k <= 65535; k++) begin
            tick();
            exp = model_next(exp);
            if (cur_state() !== exp) bad++;
            if (k < 65535 && cur_state() == 16'h0001) early++;
            if (k == 65535) ret = (cur_state() == 16'h0001) ? 1 : 0;
        end
        enable = 1'b0;
        check("R8 path matches model", 16'(bad), 16'h0);
        check("R8 no early return", 16'(early), 16'h0);
        check("R8 wrap at 65535", 16'(ret), 16'h1);
    endtask

    task automatic t_zero();
        do_load(16'h0000);
        enable = 1'b1;
        for (int k = 0; k < 10; k++) tick();
        enable = 1'b0;
        check("R9 zero lock-up", cur_state(), 16'h0000);
    endtask

    task automatic t_reset_midrun();
        do_load(16'h4321);
        enable = 1'b1;
        tick(); tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1; enable = 1'b0;
        check("R1 reset during run", cur_state(), TB_RST);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_priority();
        t_hold();
        t_step(16'hACE1, 20, "R5 step from ACE1");
        t_step(16'h8000, 20, "R5 step from 8000");
        t_step(16'hFFFF, 20, "R5 step from FFFF");
        t_nibbles();
        t_repeat();
        t_zero();
        t_reset_midrun();
        t_period();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule